// File: doc/BRIEF.md
# DDR Read Strobe Delay Calibration Sequencer

This block runs one pass of automatic read-strobe calibration for a DDR memory interface. Software has already closed all open banks and loaded a starting delay for each byte lane's read strobe. It then pulses a start input. The sequencer asks the delay lines to apply their offsets and waits until every lane confirms. It then waits a mode-register settling interval, sends one read command to the command scheduler, and opens a compare window of 16 or 32 cycles. Each byte that returns during the window is checked against the expected pattern. When the window closes, the sequencer reports a pass or fail flag for each lane.

The expected data comes from one of two sources. In device-register mode, the memory returns its fixed training readout, which is 0x00 on even beats and 0xFF on odd beats. In programmed-pattern mode, software supplies two pattern words: the first is used on even beats and the second on odd beats. To put that pattern into the memory, software first pulses a dummy-write input. The sequencer then issues a write command on its own. The scheduler takes the write data from the two pattern words and writes them to bank 0, row 0, column 0.

Commands leave the block over a valid/ready handshake with a two-bit type code. A lane that fails tells software that its starting strobe position lies outside the data eye.

Top module: `rd_dly_cal`

## Requirements
- R1: After reset, calBusy, calDone, dlyLoad, cmdValid and every laneErr bit are 0.
- R2: A calStart pulse while idle sets calBusy and clears calDone. On the next cycle dlyLoad pulses for one cycle. No read command is issued while any dlyApplied bit is low.
- R3: The read command is issued exactly TMOD_CYC+4 cycles after the clock edge at which all dlyApplied bits are first seen high. With dlyApplied held high, cmdValid first appears TMOD_CYC+5 cycles after the start edge.
- R4: cmdValid and cmdType stay unchanged until cmdReady is sampled high. The read code is 2'b01 and the write code is 2'b10.
- R5: calDone rises and calBusy falls at the same time. This happens 16 cycles after the read handshake edge when cmpLong=0, and 32 cycles after it when cmpLong=1.
- R6: The expected byte for lane L is compared with rdData[8L+7:8L]. When useMpr=1 it is 0x00 on even beats and 0xFF on odd beats. When useMpr=0 it is byte L of patA on even beats and byte L of patB on odd beats.
- R7: The burst length is 4 beats when burst8=0 and 8 beats when burst8=1. A mismatch on any beat of the burst sets only that lane's laneErr bit.
- R8: If fewer beats than the burst length arrive inside the compare window, every laneErr bit is set.
- R9: Beats beyond the burst length, and rdValid outside the compare window, do not affect laneErr.
- R10: A dummyWr pulse while idle with useMpr=0 issues one write command. With useMpr=1 the pulse is ignored and no command appears.
- R11: laneErr holds its value until the next calStart, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calStart | input | 1 | One-cycle start of calibration |
| dummyWr | input | 1 | One-cycle request for the pattern dummy write |
| useMpr | input | 1 | 1: compare against the device training readout; 0: compare against the programmed pattern |
| burst8 | input | 1 | 1: burst of 8 beats; 0: burst of 4 beats |
| cmpLong | input | 1 | 1: 32-cycle compare window; 0: 16-cycle window |
| patA | input | 8*LANES | Programmed pattern for even beats, one byte per lane |
| patB | input | 8*LANES | Programmed pattern for odd beats, one byte per lane |
| dlyLoad | output | 1 | Pulse asking the delay lines to apply their absolute offsets |
| dlyApplied | input | LANES | Per-lane level: the offset is in effect |
| cmdValid | output | 1 | Command request to the scheduler |
| cmdType | output | 2 | Command code: 01 read, 10 write |
| cmdReady | input | 1 | Scheduler accepts the command |
| rdValid | input | 1 | Read beat present on rdData |
| rdData | input | 8*LANES | Read beat, one byte per lane |
| calBusy | output | 1 | Calibration in progress; clears itself at completion |
| calDone | output | 1 | Compare phase finished; cleared by the next start |
| laneErr | output | LANES | Per-lane sticky mismatch flag |

## Verification
The hardest case to reach is the compare window closing before the burst is complete. This requires read data that arrives too late or comes up short, which a well-behaved scheduler never produces. The stimulus table therefore controls the number of beats delivered for each run, sending six beats into an eight-beat burst. It also sends beats past a four-beat burst, with corruption placed only on an ignored beat. A directed run holds the delay-applied levels low, then raises them a few lanes at a time. The same run holds back cmdReady to show that the sequencer waits at both points.

// File: rtl/rd_dly_cal_pkg.sv
package rd_dly_cal_pkg;

  typedef enum logic [1:0] {
    CMD_NONE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DWR,
    ST_DLY,
    ST_SETTLE,
    ST_RDCMD,
    ST_RDWAIT
  } state_e;

  // strobes from control to the compare datapath
  typedef struct packed {
    logic clearErr;
    logic window;
    logic commit;
  } strb_t;

endpackage

// File: rtl/rd_dly_cal_ctrl.sv
module rd_dly_cal_ctrl
  import rd_dly_cal_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int TMOD_CYC   = 6,
  parameter int WAIT_SHORT = 16,
  parameter int WAIT_LONG  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             calStart,
  input  logic             dummyWr,
  input  logic             useMpr,
  input  logic             cmpLong,
  input  logic [LANES-1:0] dlyApplied,
  input  logic             cmdReady,
  output logic             dlyLoad,
  output logic             cmdValid,
  output logic [1:0]       cmdType,
  output logic             calBusy,
  output logic             calDone,
  output strb_t            strb
);

  localparam int SETTLE_LOAD = TMOD_CYC + 4;
  localparam int CNT_MAX     = (SETTLE_LOAD > WAIT_LONG) ? SETTLE_LOAD : WAIT_LONG;
  localparam int CNT_W       = $clog2(CNT_MAX + 1);

  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             cntLast;
  logic             allApplied;

  assign allApplied = &dlyApplied;
  assign cntLast    = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      calDone <= 1'b0;
      dlyLoad <= 1'b0;
    end else begin
      dlyLoad <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (calStart) begin
            state   <= ST_DLY;
            dlyLoad <= 1'b1;
            calDone <= 1'b0;
          end else if (dummyWr && !useMpr) begin
            state <= ST_DWR;
          end
        end
        ST_DWR: begin
          if (cmdReady) state <= ST_IDLE;
        end
        ST_DLY: begin
          if (allApplied) begin
            state <= ST_SETTLE;
            cnt   <= CNT_W'(SETTLE_LOAD);
          end
        end
        ST_SETTLE: begin
          if (cntLast) state <= ST_RDCMD;
          else         cnt   <= cnt - CNT_W'(1);
        end
        ST_RDCMD: begin
          if (cmdReady) begin
            state <= ST_RDWAIT;
            cnt   <= cmpLong ? CNT_W'(WAIT_LONG) : CNT_W'(WAIT_SHORT);
          end
        end
        ST_RDWAIT: begin
          if (cntLast) begin
            state   <= ST_IDLE;
            calDone <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmdValid = 1'b0;
    cmdType  = CMD_NONE;
    if (state == ST_RDCMD) begin
      cmdValid = 1'b1;
      cmdType  = CMD_READ;
    end else if (state == ST_DWR) begin
      cmdValid = 1'b1;
      cmdType  = CMD_WRITE;
    end
  end

  assign calBusy = (state == ST_DLY) || (state == ST_SETTLE) ||
                   (state == ST_RDCMD) || (state == ST_RDWAIT);

  always_comb begin
    strb.clearErr = (state == ST_IDLE) && calStart;
    strb.window   = (state == ST_RDWAIT);
    strb.commit   = (state == ST_RDWAIT) && cntLast;
  end

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdType));

  // R4
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $countones(cmdType) == 1);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> !calBusy && $fell(calBusy));

  // R3
  settle_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_SETTLE |-> cnt != '0 && cnt <= CNT_W'(SETTLE_LOAD));

  // R2
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlyLoad |=> !dlyLoad);

endmodule

// File: rtl/rd_dly_cal_dp.sv
module rd_dly_cal_dp
  import rd_dly_cal_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strb_t              strb,
  input  logic               useMpr,
  input  logic               burst8,
  input  logic [8*LANES-1:0] patA,
  input  logic [8*LANES-1:0] patB,
  input  logic               rdValid,
  input  logic [8*LANES-1:0] rdData,
  output logic [LANES-1:0]   laneErr
);

  localparam int BC_W = $clog2(BL_LONG + 1);

  logic [BC_W-1:0]  beatCnt;
  logic [BC_W-1:0]  nextCnt;
  logic [BC_W-1:0]  burstLen;
  logic [LANES-1:0] accErr;
  logic [LANES-1:0] nextAcc;
  logic [LANES-1:0] laneMis;
  logic             accept;
  logic             oddBeat;

  assign burstLen = burst8 ? BC_W'(BL_LONG) : BC_W'(BL_SHORT);
  assign accept   = strb.window && rdValid && (beatCnt < burstLen);
  assign oddBeat  = beatCnt[0];

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [7:0] expByte;
    always_comb begin
      if (useMpr) expByte = oddBeat ? 8'hFF : 8'h00;
      else        expByte = oddBeat ? patB[8*lane +: 8] : patA[8*lane +: 8];
    end
    assign laneMis[lane] = (rdData[8*lane +: 8] != expByte);
  end

  assign nextAcc = accErr | (accept ? laneMis : '0);
  assign nextCnt = beatCnt + (accept ? BC_W'(1) : BC_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatCnt <= '0;
      accErr  <= '0;
      laneErr <= '0;
    end else if (strb.clearErr) begin
      beatCnt <= '0;
      accErr  <= '0;
      laneErr <= '0;
    end else begin
      beatCnt <= nextCnt;
      accErr  <= nextAcc;
      if (strb.commit)
        laneErr <= nextAcc | {LANES{nextCnt < burstLen}};
    end
  end

  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clearErr && !strb.commit |=> $stable(laneErr));

  // R9
  beat_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatCnt <= BC_W'(BL_LONG));

  // R9
  no_count_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.window && !strb.clearErr |=> $stable(beatCnt));

endmodule

// File: rtl/rd_dly_cal.sv
module rd_dly_cal
  import rd_dly_cal_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int TMOD_CYC   = 6,
  parameter int WAIT_SHORT = 16,
  parameter int WAIT_LONG  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               calStart,
  input  logic               dummyWr,
  input  logic               useMpr,
  input  logic               burst8,
  input  logic               cmpLong,
  input  logic [8*LANES-1:0] patA,
  input  logic [8*LANES-1:0] patB,
  output logic               dlyLoad,
  input  logic [LANES-1:0]   dlyApplied,
  output logic               cmdValid,
  output logic [1:0]         cmdType,
  input  logic               cmdReady,
  input  logic               rdValid,
  input  logic [8*LANES-1:0] rdData,
  output logic               calBusy,
  output logic               calDone,
  output logic [LANES-1:0]   laneErr
);

  strb_t strb;

  rd_dly_cal_ctrl #(
    .LANES      (LANES),
    .TMOD_CYC   (TMOD_CYC),
    .WAIT_SHORT (WAIT_SHORT),
    .WAIT_LONG  (WAIT_LONG)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .calStart   (calStart),
    .dummyWr    (dummyWr),
    .useMpr     (useMpr),
    .cmpLong    (cmpLong),
    .dlyApplied (dlyApplied),
    .cmdReady   (cmdReady),
    .dlyLoad    (dlyLoad),
    .cmdValid   (cmdValid),
    .cmdType    (cmdType),
    .calBusy    (calBusy),
    .calDone    (calDone),
    .strb       (strb)
  );

  rd_dly_cal_dp #(
    .LANES    (LANES),
    .BL_SHORT (4),
    .BL_LONG  (8)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .useMpr  (useMpr),
    .burst8  (burst8),
    .patA    (patA),
    .patB    (patB),
    .rdValid (rdValid),
    .rdData  (rdData),
    .laneErr (laneErr)
  );

endmodule

// File: tb/rd_dly_cal_test.sv
module rd_dly_cal_test;

  localparam int PERIOD = 10;
  localparam int LANES  = 4;
  localparam int TMOD   = 6;
  localparam logic [31:0] PA = 32'hA1B2C3D4;
  localparam logic [31:0] PB = 32'h1E2D3C4B;

  typedef struct packed {
    logic       mpr;
    logic       bl8;
    logic       lng;
    logic [3:0] mask;
    logic [2:0] cbeat;
    logic [3:0] nbeats;
    logic [3:0] expErr;
  } vec_t;

  // R6 R7 R8 R9 R11: vector 5 follows an all-fail run and must come back clean
  localparam vec_t VECS [7] = '{
    '{1'b1, 1'b1, 1'b0, 4'h0, 3'd0, 4'd8, 4'h0},
    '{1'b1, 1'b0, 1'b0, 4'h2, 3'd3, 4'd4, 4'h2},
    '{1'b0, 1'b1, 1'b0, 4'h8, 3'd7, 4'd8, 4'h8},
    '{1'b0, 1'b0, 1'b1, 4'h5, 3'd0, 4'd4, 4'h5},
    '{1'b0, 1'b1, 1'b0, 4'h0, 3'd0, 4'd6, 4'hF},
    '{1'b0, 1'b0, 1'b0, 4'h4, 3'd5, 4'd6, 4'h0},
    '{1'b1, 1'b1, 1'b1, 4'hF, 3'd2, 4'd8, 4'hF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calStart = 1'b0, dummyWr = 1'b0, useMpr = 1'b1, burst8 = 1'b1, cmpLong = 1'b0;
  logic [8*LANES-1:0] patA = PA, patB = PB;
  logic dlyLoad;
  logic [LANES-1:0] dlyApplied = '1;
  logic cmdValid;
  logic [1:0] cmdType;
  logic cmdReady = 1'b1;
  logic rdValid = 1'b0;
  logic [8*LANES-1:0] rdData = '0;
  logic calBusy, calDone;
  logic [LANES-1:0] laneErr;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  rd_dly_cal #(.LANES(LANES), .TMOD_CYC(TMOD)) uut (
    .clk(clk), .rstN(rstN), .calStart(calStart), .dummyWr(dummyWr),
    .useMpr(useMpr), .burst8(burst8), .cmpLong(cmpLong), .patA(patA), .patB(patB),
    .dlyLoad(dlyLoad), .dlyApplied(dlyApplied), .cmdValid(cmdValid), .cmdType(cmdType),
    .cmdReady(cmdReady), .rdValid(rdValid), .rdData(rdData),
    .calBusy(calBusy), .calDone(calDone), .laneErr(laneErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] beatByte(input logic mpr, input int lane, input int beat,
                                          input logic [3:0] mask, input int cbeat);
    logic [7:0] b;
    if (mpr) b = (beat % 2 == 1) ? 8'hFF : 8'h00;
    else     b = (beat % 2 == 1) ? PB[8*lane +: 8] : PA[8*lane +: 8];
    if (mask[lane] && beat == cbeat) b = b ^ 8'h5A;
    return b;
  endfunction

  // at a negedge where cmdValid is high and cmdReady high; returns cycles to calDone
  task automatic doRead(input logic mpr, input int nbeats, input logic [3:0] mask,
                        input int cbeat, output int waitN);
    int m;
    @(negedge clk);
    m = 0;
    while (!calDone && m < 100) begin
      if (m >= 2 && m - 2 < nbeats) begin
        rdValid = 1'b1;
        for (int l = 0; l < LANES; l++) rdData[8*l +: 8] = beatByte(mpr, l, m - 2, mask, cbeat);
      end else begin
        rdValid = 1'b0;
      end
      @(negedge clk);
      m++;
    end
    rdValid = 1'b0;
    waitN = m;
  endtask

  task automatic pulseStart();
    @(negedge clk);
    calStart = 1'b1;
    @(negedge clk);
    calStart = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int settleN, waitN;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", calBusy, 0);
    chk("R1 done", calDone, 0);
    chk("R1 cmdValid", cmdValid, 0);
    chk("R1 dlyLoad", dlyLoad, 0);
    chk("R1 laneErr", laneErr, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      useMpr = VECS[v].mpr;
      burst8 = VECS[v].bl8;
      cmpLong = VECS[v].lng;
      pulseStart();
      settleN = 0;
      while (!cmdValid && settleN < 100) begin
        @(negedge clk);
        settleN++;
      end
      chk("R3 settle cycles", settleN, TMOD + 5);
      chk("R4 read code", cmdType, 2'b01);
      doRead(VECS[v].mpr, int'(VECS[v].nbeats), VECS[v].mask, int'(VECS[v].cbeat), waitN);
      chk("R5 wait cycles", waitN, VECS[v].lng ? 32 : 16);
      chk("R5 busy cleared", calBusy, 0);
      chk("R7 R8 R9 laneErr", laneErr, VECS[v].expErr);
      repeat (3) @(negedge clk);
      chk("R11 laneErr held", laneErr, VECS[v].expErr);
    end

    // R2: waiting for all lanes; R11 errors cleared by start; R4 read held under backpressure
    useMpr = 1'b1; burst8 = 1'b0; cmpLong = 1'b0;
    dlyApplied = 4'b0000;
    cmdReady = 1'b0;
    pulseStart();
    chk("R2 dlyLoad pulse", dlyLoad, 1);
    chk("R2 busy set", calBusy, 1);
    chk("R2 done cleared", calDone, 0);
    chk("R11 laneErr cleared", laneErr, 0);
    @(negedge clk);
    chk("R2 dlyLoad single", dlyLoad, 0);
    repeat (10) @(negedge clk);
    chk("R2 no read before lanes", cmdValid, 0);
    dlyApplied = 4'b0111;
    repeat (5) @(negedge clk);
    chk("R2 no read with one lane low", cmdValid, 0);
    dlyApplied = 4'b1111;
    settleN = 0;
    while (!cmdValid && settleN < 100) begin
      @(negedge clk);
      settleN++;
    end
    chk("R3 settle after lanes", settleN, TMOD + 5);
    repeat (3) @(negedge clk);
    chk("R4 read held", cmdValid, 1);
    chk("R4 read type held", cmdType, 2'b01);
    cmdReady = 1'b1;
    doRead(1'b1, 4, 4'h0, 0, waitN);
    chk("R5 wait short", waitN, 16);
    chk("R6 R7 mpr burst4 clean", laneErr, 0);

    // R9: rdValid outside the window does not change laneErr
    rdValid = 1'b1;
    rdData = 32'hDEADBEEF;
    repeat (4) @(negedge clk);
    rdValid = 1'b0;
    chk("R9 beats outside window", laneErr, 0);

    // R10: dummy write in programmed mode
    useMpr = 1'b0;
    cmdReady = 1'b0;
    @(negedge clk);
    dummyWr = 1'b1;
    @(negedge clk);
    dummyWr = 1'b0;
    chk("R10 write issued", cmdValid, 1);
    chk("R10 write code", cmdType, 2'b10);
    chk("R10 no calibration", calBusy, 0);
    repeat (2) @(negedge clk);
    chk("R4 write held", cmdValid, 1);
    cmdReady = 1'b1;
    @(negedge clk);
    chk("R10 single write", cmdValid, 0);

    // R10: ignored in device-register mode
    useMpr = 1'b1;
    dummyWr = 1'b1;
    @(negedge clk);
    dummyWr = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 ignored in mpr mode", cmdValid, 0);
      @(negedge clk);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule